// File: doc/BRIEF.md
# Reference-Divided Test Clock Block

This block produces the full set of output clock nets of a clock generator while the chip is in its production test setting. In that setting every clock is taken straight from the reference input by integer division, so a tester can drive the reference pin and predict every output edge. The reference net passes through at full rate. The high-speed USB-rate net and the processor/memory net run at half the reference rate. The low-rate peripheral net runs at a quarter of it. The bus group runs at a quarter or a third, depending on the latched bus-select bit.

Outside test mode, each output carries an externally supplied normal-mode clock that the frequency synthesizer produces. Test mode, the output-disable (tristate) request and the bus-select bit are sampled only while the synchronous active-low reset is held. After reset they stay frozen, so the outputs never switch source while running. All dividers leave reset on the same reference edge, which gives every divided output a rising edge on that edge.

Top module: `refdiv_test_clocks`

## Requirements
- R1: While `rst_n` is low at a rising `ref_clk` edge, every divider returns to its start state with its output low. On the first rising edge after `rst_n` goes high, all divided outputs (half, quarter and third) rise together.
- R2: In test mode, `ref_out` equals `ref_clk`: high in the first half of each reference period and low in the second.
- R3: In test mode, `usb_out` is the reference divided by 2. It is high on the 1st, 3rd, 5th and following odd cycles counted from reset release.
- R4: In test mode, `low_out` is the reference divided by 4. It is high for two cycles and then low for two, starting with cycle 1.
- R5: In test mode, `cpu_out` is the reference divided by 2 and is in phase with `usb_out`.
- R6: In test mode with the latched `bus_sel` = 1, `bus_out` is the reference divided by 4 and is in phase with `low_out`.
- R7: In test mode with the latched `bus_sel` = 0, `bus_out` is the reference divided by 3. It is high for one cycle and low for two, and is high on cycles 1, 4, 7 and so on.
- R8: All five output enables are 0 when the latched `tri_en` is 1, and all are 1 when it is 0.
- R9: When the latched `test_en` is 0, each output equals its `nrm_*_clk` input combinationally.
- R10: Changes on `test_en`, `tri_en` or `bus_sel` while `rst_n` is high have no effect on the source, rate or enables of any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; mode inputs are sampled while low |
| test_en | input | 1 | Test-mode request (1 = outputs derived from the reference) |
| tri_en | input | 1 | Output-disable request (1 = all output enables low) |
| bus_sel | input | 1 | Bus rate select: 1 = reference/4, 0 = reference/3 in test mode |
| nrm_ref_clk | input | 1 | Normal-mode clock for the reference output |
| nrm_usb_clk | input | 1 | Normal-mode clock for the USB-rate output |
| nrm_low_clk | input | 1 | Normal-mode clock for the low-rate output |
| nrm_cpu_clk | input | 1 | Normal-mode clock for the processor/memory output |
| nrm_bus_clk | input | 1 | Normal-mode clock for the bus output |
| ref_out | output | 1 | Reference / interrupt-controller clock net |
| ref_oe | output | 1 | Output enable for `ref_out` |
| usb_out | output | 1 | USB-rate clock net |
| usb_oe | output | 1 | Output enable for `usb_out` |
| low_out | output | 1 | Low-rate peripheral clock net |
| low_oe | output | 1 | Output enable for `low_out` |
| cpu_out | output | 1 | Processor and memory clock net |
| cpu_oe | output | 1 | Output enable for `cpu_out` |
| bus_out | output | 1 | Bus clock net |
| bus_oe | output | 1 | Output enable for `bus_out` |

## Verification
The /2, /4 and /3 dividers all rise on the first edge after reset release, and they coincide again every twelfth cycle. A third-rate bus edge can therefore land in the same cycle as a half- and quarter-rate edge. The bench releases reset with `bus_sel` low and follows fourteen cycles, which covers both coincidences. Each output is compared cycle by cycle against a pattern computed from the cycle index. The same run holds the output-disable request and then flips every mode input after release, so the frozen-mode behaviour and the disabled enables are judged while the dividers are running.

// File: rtl/refdiv_pkg.sv
// Shared types and helpers for the reference-divided test clock block.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package refdiv_pkg;

    // Mode bits captured while reset is held
    typedef struct packed {
        logic test_on;      // outputs derived from reference
        logic hiz_on;       // output enables forced low
        logic bus_quarter;  // bus group at /4 (else /3)
    } refdiv_mode_t;

    // Index of each shared divider instance
    localparam int NUM_DIV     = 3;
    localparam int IDX_HALF    = 0;
    localparam int IDX_QUARTER = 1;
    localparam int IDX_THIRD   = 2;

    // Picks the ratio for a divider slot
    function automatic int pick_ratio(input int idx, input int r_half,
                                      input int r_quarter, input int r_third);
        case (idx)
            IDX_HALF:    return r_half;
            IDX_QUARTER: return r_quarter;
            default:     return r_third;
        endcase
    endfunction

endpackage

// File: rtl/refdiv_mode_latch.sv
// Captures the mode inputs while reset is held and freezes them after.
// Assumes: rst_n is synchronous to clk and held for at least one edge.
module refdiv_mode_latch
    import refdiv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         tri_en,
    input  logic         bus_sel,
    output refdiv_mode_t mode_q
);

    // Sample the requests only during reset; hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.test_on     <= test_en;
            mode_q.hiz_on      <= tri_en;
            mode_q.bus_quarter <= bus_sel;
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q)); // R10

endmodule

// File: rtl/refdiv_divider.sv
// Integer clock divider: output high for RATIO/2 cycles, low for the rest.
// Assumes: RATIO >= 2; reset is synchronous and active low. Leaves reset
// so that the output rises on the first edge after release.
module refdiv_divider #(
    parameter int RATIO = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_q
);

    localparam int CW     = $clog2(RATIO);
    localparam int HIGH_N = RATIO / 2;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Next count value with wrap at the last phase
    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Phase counter and registered output; reset parks on the last phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            div_q <= (cnt_nxt < CW'(HIGH_N));
        end
    end

    AST_DIV_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> div_q); // R1

endmodule

// File: rtl/refdiv_out_mux.sv
// Selects each output net between its divided test clock and its
// normal-mode clock, and drives the output enables.
// Assumes: mode is static after reset, so the selects never move while
// clocks run.
module refdiv_out_mux
    import refdiv_pkg::*;
(
    input  logic         ref_clk,
    input  refdiv_mode_t mode_q,
    input  logic         div_half,
    input  logic         div_quarter,
    input  logic         div_third,
    input  logic         nrm_ref_clk,
    input  logic         nrm_usb_clk,
    input  logic         nrm_low_clk,
    input  logic         nrm_cpu_clk,
    input  logic         nrm_bus_clk,
    output logic [4:0]   clk_out,
    output logic [4:0]   oe_out
);

    logic bus_test;

    // Bus group rate choice in test mode
    always_comb begin
        bus_test = mode_q.bus_quarter ? div_quarter : div_third;
    end

    // Per-net source select: order is ref, usb, low, cpu, bus (bit 4..0)
    always_comb begin
        if (mode_q.test_on) begin
            clk_out = {ref_clk, div_half, div_quarter, div_half, bus_test};
        end else begin
            clk_out = {nrm_ref_clk, nrm_usb_clk, nrm_low_clk,
                       nrm_cpu_clk, nrm_bus_clk};
        end
    end

    // Output enables follow the latched disable request
    always_comb begin
        oe_out = {5{~mode_q.hiz_on}};
    end

endmodule

// File: rtl/refdiv_test_clocks.sv
// Top: test-mode reference clock dividers with normal-mode bypass.
// Assumes: ref_clk is the crystal/tester reference; the nrm_* clocks come
// from the synthesizer; rst_n is synchronous to ref_clk.
module refdiv_test_clocks
    import refdiv_pkg::*;
#(
    parameter int RATIO_HALF    = 2,
    parameter int RATIO_QUARTER = 4,
    parameter int RATIO_THIRD   = 3
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic tri_en,
    input  logic bus_sel,
    input  logic nrm_ref_clk,
    input  logic nrm_usb_clk,
    input  logic nrm_low_clk,
    input  logic nrm_cpu_clk,
    input  logic nrm_bus_clk,
    output logic ref_out,
    output logic ref_oe,
    output logic usb_out,
    output logic usb_oe,
    output logic low_out,
    output logic low_oe,
    output logic cpu_out,
    output logic cpu_oe,
    output logic bus_out,
    output logic bus_oe
);

    refdiv_mode_t       mode_q;
    logic [NUM_DIV-1:0] div_q;
    logic [4:0]         clk_out;
    logic [4:0]         oe_out;

    refdiv_mode_latch u_mode (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .tri_en  (tri_en),
        .bus_sel (bus_sel),
        .mode_q  (mode_q)
    );

    // One shared divider per distinct ratio, all reset together
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        refdiv_divider #(
            .RATIO (pick_ratio(g, RATIO_HALF, RATIO_QUARTER, RATIO_THIRD))
        ) u_div (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .div_q (div_q[g])
        );
    end

    refdiv_out_mux u_mux (
        .ref_clk     (ref_clk),
        .mode_q      (mode_q),
        .div_half    (div_q[IDX_HALF]),
        .div_quarter (div_q[IDX_QUARTER]),
        .div_third   (div_q[IDX_THIRD]),
        .nrm_ref_clk (nrm_ref_clk),
        .nrm_usb_clk (nrm_usb_clk),
        .nrm_low_clk (nrm_low_clk),
        .nrm_cpu_clk (nrm_cpu_clk),
        .nrm_bus_clk (nrm_bus_clk),
        .clk_out     (clk_out),
        .oe_out      (oe_out)
    );

    // Unpack the mux bundle onto the named ports
    always_comb begin
        {ref_out, usb_out, low_out, cpu_out, bus_out} = clk_out;
        {ref_oe,  usb_oe,  low_oe,  cpu_oe,  bus_oe}  = oe_out;
    end

    AST_HALF_TOGGLES: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(rst_n) |-> (div_q[IDX_HALF] != $past(div_q[IDX_HALF]))); // R5
    AST_QUARTER_ON_HALF: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(div_q[IDX_QUARTER]) |-> $rose(div_q[IDX_HALF])); // R4
    AST_THIRD_ONE_HIGH: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(div_q[IDX_THIRD]) |=> !div_q[IDX_THIRD]); // R7
    AST_THIRD_TWO_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(div_q[IDX_THIRD]) |=> !div_q[IDX_THIRD]); // R7

endmodule

// File: tb/refdiv_test_clocks_bench.sv
// Scoreboard bench: drivers queue expected output vectors, a monitor pops
// one per reference cycle and compares it with the ports.
module refdiv_test_clocks_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [4:0] exp_clk;   // ref, usb, low, cpu, bus
        logic       exp_oe;
        bit         test_kind; // 1: test-mode item, 0: normal-mode item
        int         bus_req;
        int         oe_req;
    } item_t;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0, tri_en = 1'b0, bus_sel = 1'b0;
    logic nrm_ref_clk = 1'b0, nrm_usb_clk = 1'b0, nrm_low_clk = 1'b0;
    logic nrm_cpu_clk = 1'b0, nrm_bus_clk = 1'b0;
    logic ref_out, ref_oe, usb_out, usb_oe, low_out, low_oe;
    logic cpu_out, cpu_oe, bus_out, bus_oe;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    item_t sb_q[$];

    refdiv_test_clocks u_refdiv_test_clocks (
        .ref_clk(ref_clk), .rst_n(rst_n), .test_en(test_en), .tri_en(tri_en),
        .bus_sel(bus_sel), .nrm_ref_clk(nrm_ref_clk), .nrm_usb_clk(nrm_usb_clk),
        .nrm_low_clk(nrm_low_clk), .nrm_cpu_clk(nrm_cpu_clk),
        .nrm_bus_clk(nrm_bus_clk), .ref_out(ref_out), .ref_oe(ref_oe),
        .usb_out(usb_out), .usb_oe(usb_oe), .low_out(low_out), .low_oe(low_oe),
        .cpu_out(cpu_out), .cpu_oe(cpu_oe), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pop one expectation per cycle, sample 3 units after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge ref_clk);
            #3;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.test_kind) begin
                    chk("R2 ref high phase", ref_out, it.exp_clk[4]);
                    chk("R3 usb /2", usb_out, it.exp_clk[3]);
                    chk("R4 low /4", low_out, it.exp_clk[2]);
                    chk("R5 cpu /2", cpu_out, it.exp_clk[1]);
                    chk($sformatf("R%0d bus", it.bus_req), bus_out, it.exp_clk[0]);
                end else begin
                    chk("R9 normal clocks", {ref_out, usb_out, low_out, cpu_out, bus_out} == it.exp_clk, 1'b1);
                end
                chk($sformatf("R%0d enables", it.oe_req),
                    (&{ref_oe, usb_oe, low_oe, cpu_oe, bus_oe}) | (|{ref_oe, usb_oe, low_oe, cpu_oe, bus_oe}) ? ref_oe & usb_oe & low_oe & cpu_oe & bus_oe : 1'b0,
                    it.exp_oe);
                chk($sformatf("R%0d enables agree", it.oe_req),
                    (ref_oe == usb_oe) && (usb_oe == low_oe) && (low_oe == cpu_oe) && (cpu_oe == bus_oe), 1'b1);
                if (it.test_kind) begin
                    #4;
                    chk("R2 ref low phase", ref_out, 1'b0);
                end
            end
        end
    end

    // Apply reset with the given mode inputs for n edges
    task automatic do_reset(input logic t, input logic z, input logic b, input int n);
        @(negedge ref_clk);
        rst_n = 1'b0; test_en = t; tri_en = z; bus_sel = b;
        repeat (n) @(negedge ref_clk);
    endtask

    // Release reset and queue n test-mode expectations computed from cycle index
    task automatic drive_test_run(input logic bsel, input logic hiz, input int n,
                                  input int oe_req);
        item_t it;
        rst_n = 1'b1;
        for (int k = 1; k <= n; k++) begin
            it.exp_clk[4] = 1'b1;
            it.exp_clk[3] = (k % 2) == 1;
            it.exp_clk[2] = ((k - 1) % 4) < 2;
            it.exp_clk[1] = (k % 2) == 1;
            it.exp_clk[0] = bsel ? (((k - 1) % 4) < 2) : (((k - 1) % 3) == 0);
            it.exp_oe     = ~hiz;
            it.test_kind  = 1'b1;
            it.bus_req    = bsel ? 6 : 7;
            it.oe_req     = oe_req;
            sb_q.push_back(it);
        end
    endtask

    task automatic wait_drain();
        while (sb_q.size() > 0) @(negedge ref_clk);
        @(negedge ref_clk);
    endtask

    // Normal mode: drive one pattern per cycle and queue it as expected
    task automatic drive_normal(input logic [4:0] p);
        item_t it;
        @(negedge ref_clk);
        {nrm_ref_clk, nrm_usb_clk, nrm_low_clk, nrm_cpu_clk, nrm_bus_clk} = p;
        it.exp_clk = p; it.exp_oe = 1'b1; it.test_kind = 1'b0;
        it.bus_req = 9; it.oe_req = 8;
        sb_q.push_back(it);
    endtask

    initial begin
        // R1: reset state of the dividers, test mode latched
        do_reset(1'b1, 1'b0, 1'b1, 3);
        #3;
        chk("R1 usb low in reset", usb_out, 1'b0);
        chk("R1 low low in reset", low_out, 1'b0);
        chk("R1 cpu low in reset", cpu_out, 1'b0);
        chk("R1 bus low in reset", bus_out, 1'b0);
        @(negedge ref_clk);

        // R6/R8: bus at /4, enables on; first item checks R1 alignment
        drive_test_run(1'b1, 1'b0, 10, 8);
        wait_drain();

        // R7/R8/R10: bus /3, disabled; coincident edges at cycles 1 and 13
        do_reset(1'b1, 1'b1, 1'b0, 2);
        drive_test_run(1'b0, 1'b1, 14, 8);
        test_en = 1'b0; tri_en = 1'b0; bus_sel = 1'b1; // R10 flipped after release
        wait_drain();
        // R10: mode inputs flipped during run, outputs keep test /3 and disable
        @(posedge ref_clk); #3;
        chk("R10 enables stay off", bus_oe, 1'b0);
        begin
            logic prev;
            prev = usb_out;
            @(posedge ref_clk); #3;
            chk("R10 still test mode", usb_out, ~prev);
        end

        // R9: normal mode passes external clocks
        do_reset(1'b0, 1'b0, 1'b0, 2);
        rst_n = 1'b1;
        drive_normal(5'b10101);
        drive_normal(5'b01010);
        drive_normal(5'b11111);
        drive_normal(5'b00000);
        drive_normal(5'b10011);
        wait_drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule